// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames from a byte-stream input into buffers described by a circular list of descriptors. The descriptors and the buffers sit in a word-addressed memory model inside the block, and software reaches that memory through a simple host port. Each descriptor occupies three consecutive words: a link to the next descriptor, a command/status word and a buffer pointer. Software hands a descriptor to the engine by writing the buffer size into the status word with the ownership flag clear.

For every frame, the engine stores the bytes into the current buffer. It then writes back a status word that sets the ownership flag and carries the byte count, a good-frame flag, the error causes reported with the last byte, the destination class and an over-length flag. It then follows the link. A frame longer than the buffer spills into the following descriptor, and the earlier descriptor is marked as continued. When the engine reaches a descriptor it still owns, it stops and discards incoming frames, counting each one as missed. A start command makes it read the descriptor it stopped on again.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset the engine is idle, `in_ready` is high, `missed_count` is 0, and the engine does not fetch a descriptor until `rx_start` is pulsed.
- R2: A descriptor at word address D has its link at D, its status word at D+1 and its buffer pointer at D+2. Link and buffer pointer are byte addresses, so the word index is the address shifted right by 2. `ring_addr` and `host_addr` are word addresses.
- R3: Byte k of a frame is stored at byte address bufptr+k. Byte lane (address mod 4) L occupies bits 8L+7:8L of the memory word.
- R4: On completion the status word has bit 31 set, bits 11:0 equal to the number of bytes stored in that descriptor (all bytes received, CRC included), and bit 27 set exactly when the frame has no error flag and is not over-long.
- R5: `in_err` is sampled with the last byte and mapped as [7]->26 abort, [6]->25 overrun, [5]->21 runt, [4]->20 invalid symbol, [3]->19 CRC, [2]->18 alignment, [1]->17 loopback, [0]->16 collision. `in_dest` goes to bits 24:23. Any error flag clears bit 27.
- R6: A frame whose total length exceeds MAX_LEN (default 1518) sets bit 22 and clears bit 27.
- R7: When a buffer fills before the last byte, that descriptor is written back with bits 31 and 30 set, count equal to the buffer size, and bits 29:12 clear. The rest of the frame continues in the next descriptor.
- R8: After each write-back the engine moves to the descriptor named by the link, so a circular ring wraps back to its first descriptor.
- R9: A fetched descriptor with bit 31 set makes the engine go idle. While it is idle, frames are accepted and discarded with no memory write, and `missed_count` rises by one at the last byte of each discarded frame.
- R10: `rx_start` while idle makes the engine read the descriptor it stopped on again. Without a start it stays idle.
- R11: `ring_load` sets the current descriptor address only while the engine is idle. While the engine is active it has no effect.
- R12: `in_ready` is low in the cycle after a start and during every descriptor fetch. `desc_done` pulses for one cycle for each status write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_start | input | 1 | Start/restart command pulse |
| ring_load | input | 1 | Load current descriptor address (idle only) |
| ring_addr | input | AW | Descriptor word address to load |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Last byte of frame |
| in_err | input | 8 | Error causes, sampled with the last byte |
| in_dest | input | 2 | Destination class, sampled with the last byte |
| in_ready | output | 1 | Byte accepted at this edge when valid |
| host_we | input | 1 | Host memory write enable |
| host_addr | input | AW | Host memory word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| desc_done | output | 1 | One-cycle pulse per status write-back |
| eng_idle | output | 1 | Engine stopped, discarding frames |
| missed_count | output | MISS_W | Saturating count of discarded frames |

## Verification
A wrong current-descriptor pointer shows up within one frame: the status word lands in the wrong descriptor, and the buffer the bench reads next holds stale data. Errors in the byte counter or the lane selection show up in the first buffer word read after the frame. A lost ownership check shows up in the next frame sent against an owned descriptor, because the earlier status and buffer contents get overwritten and `missed_count` does not rise. A bad spill decision shows up in the status of the first descriptor, in the continued-frame flag and its count, within a few cycles of the buffer filling.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;

    localparam int SZ_W    = 12;
    localparam int OFF_LNK = 0;
    localparam int OFF_STS = 1;
    localparam int OFF_BUF = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_STS,
        S_RD_BUF,
        S_RD_LNK,
        S_RECV,
        S_WB
    } rx_state_e;

    typedef struct packed {
        logic abort;
        logic overrun;
        logic runt;
        logic invalid;
        logic crc;
        logic align;
        logic loopb;
        logic coll;
    } rx_err_t;

    typedef struct packed {
        logic            own;
        logic            more;
        logic            intr;
        logic            nocrc;
        logic            good;
        logic            abort;
        logic            overrun;
        logic [1:0]      dest;
        logic            too_long;
        logic            runt;
        logic            invalid;
        logic            crc;
        logic            align;
        logic            loopb;
        logic            coll;
        logic [3:0]      rsvd;
        logic [SZ_W-1:0] count;
    } rx_status_t;

    function automatic logic [31:0] pack_status(
        input logic            more,
        input logic [SZ_W-1:0] count,
        input rx_err_t         err,
        input logic [1:0]      dest,
        input logic            too_long
    );
        rx_status_t s;
        s       = '0;
        s.own   = 1'b1;
        s.more  = more;
        s.count = count;
        if (!more) begin
            s.abort    = err.abort;
            s.overrun  = err.overrun;
            s.runt     = err.runt;
            s.invalid  = err.invalid;
            s.crc      = err.crc;
            s.align    = err.align;
            s.loopb    = err.loopb;
            s.coll     = err.coll;
            s.dest     = dest;
            s.too_long = too_long;
            s.good     = (err == '0) && !too_long;
        end
        return s;
    endfunction

endpackage

// File: rtl/rxr_mem.sv
`timescale 1ns/1ps
module rxr_mem #(
    parameter int WORDS = 2048,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [31:0]   h_wdata,
    output logic [31:0]   h_rdata,
    input  logic          e_we,
    input  logic [3:0]    e_be,
    input  logic [AW-1:0] e_addr,
    input  logic [31:0]   e_wdata,
    output logic [31:0]   e_rdata
);
    logic [31:0] mem [WORDS];

    // Engine lanes are applied after the host word, so the engine wins on a clash.
    always_ff @(posedge clk) begin
        if (h_we) mem[h_addr] <= h_wdata;
        for (int b = 0; b < 4; b++) begin
            if (e_we && e_be[b]) mem[e_addr][8*b +: 8] <= e_wdata[8*b +: 8];
        end
    end

    assign h_rdata = mem[h_addr];
    assign e_rdata = mem[e_addr];

    // R3
    one_lane_chk: assert property (@(posedge clk)
        (e_we && e_be != 4'hF) |-> $onehot0(e_be));

endmodule

// File: rtl/rxr_miss_ctr.sv
`timescale 1ns/1ps
module rxr_miss_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                     count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end

    // R9
    miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(inc) |-> $stable(count));

endmodule

// File: rtl/rxr_ctrl.sv
`timescale 1ns/1ps
module rxr_ctrl
    import rxr_pkg::*;
#(
    parameter int AW      = 11,
    parameter int MAX_LEN = 1518,
    parameter int TOT_W   = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_start,
    input  logic          ring_load,
    input  logic [AW-1:0] ring_addr,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic [7:0]    in_err,
    input  logic [1:0]    in_dest,
    output logic          in_ready,
    output logic          e_we,
    output logic [3:0]    e_be,
    output logic [AW-1:0] e_addr,
    output logic [31:0]   e_wdata,
    input  logic [31:0]   e_rdata,
    output logic          desc_done,
    output logic          idle,
    output logic          miss_inc
);
    localparam int BW = AW + 2;

    rx_state_e       st_q;
    logic [AW-1:0]   cur_q;
    logic [AW-1:0]   link_q;
    logic [BW-1:0]   buf_q;
    logic [SZ_W-1:0] size_q;
    logic [SZ_W-1:0] cnt_q;
    logic [TOT_W-1:0] tot_q;
    logic            in_frame_q;
    logic            drop_q;
    logic            pend_q;
    logic            more_q;
    rx_err_t         err_q;
    logic [1:0]      dest_q;

    logic [BW-1:0]   byte_addr;
    logic            drop_nxt;
    logic            pend_nxt;
    logic            buf_full;
    logic            too_long;
    logic            unused_rd;

    assign unused_rd = ^e_rdata;

    assign byte_addr = buf_q + BW'(cnt_q);
    assign in_ready  = (st_q == S_IDLE) || (st_q == S_RECV);
    assign idle      = (st_q == S_IDLE);
    assign desc_done = (st_q == S_WB);
    assign miss_inc  = idle && in_valid && in_last;
    assign drop_nxt  = (idle && in_valid) ? !in_last : drop_q;
    assign pend_nxt  = pend_q | rx_start;
    assign buf_full  = (cnt_q + 1'b1) == size_q;
    assign too_long  = tot_q > TOT_W'(MAX_LEN);

    always_comb begin
        e_we    = 1'b0;
        e_be    = 4'b0001 << byte_addr[1:0];
        e_wdata = {4{in_data}};
        e_addr  = cur_q;
        case (st_q)
            S_RD_STS: e_addr = cur_q + AW'(OFF_STS);
            S_RD_BUF: e_addr = cur_q + AW'(OFF_BUF);
            S_RD_LNK: e_addr = cur_q + AW'(OFF_LNK);
            S_RECV: begin
                e_addr = byte_addr[BW-1:2];
                e_we   = in_valid;
            end
            S_WB: begin
                e_addr  = cur_q + AW'(OFF_STS);
                e_we    = 1'b1;
                e_be    = 4'hF;
                e_wdata = pack_status(more_q, cnt_q, err_q, dest_q, too_long);
            end
            default: e_addr = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= S_IDLE;
            cur_q      <= '0;
            link_q     <= '0;
            buf_q      <= '0;
            size_q     <= '0;
            cnt_q      <= '0;
            tot_q      <= '0;
            in_frame_q <= 1'b0;
            drop_q     <= 1'b0;
            pend_q     <= 1'b0;
            more_q     <= 1'b0;
            err_q      <= '0;
            dest_q     <= '0;
        end else begin
            case (st_q)
                S_IDLE: begin
                    if (ring_load) cur_q <= ring_addr;
                    drop_q <= drop_nxt;
                    if (pend_nxt && !drop_nxt) begin
                        pend_q <= 1'b0;
                        st_q   <= S_RD_STS;
                    end else begin
                        pend_q <= pend_nxt;
                    end
                end
                S_RD_STS: begin
                    if (e_rdata[31]) begin
                        drop_q     <= in_frame_q;
                        in_frame_q <= 1'b0;
                        st_q       <= S_IDLE;
                    end else begin
                        size_q <= e_rdata[SZ_W-1:0];
                        st_q   <= S_RD_BUF;
                    end
                end
                S_RD_BUF: begin
                    buf_q <= e_rdata[BW-1:0];
                    st_q  <= S_RD_LNK;
                end
                S_RD_LNK: begin
                    link_q <= e_rdata[BW-1:2];
                    cnt_q  <= '0;
                    st_q   <= S_RECV;
                end
                S_RECV: begin
                    if (in_valid) begin
                        cnt_q      <= cnt_q + 1'b1;
                        tot_q      <= in_frame_q ? tot_q + 1'b1 : TOT_W'(1);
                        in_frame_q <= 1'b1;
                        if (in_last) begin
                            err_q  <= rx_err_t'(in_err);
                            dest_q <= in_dest;
                            more_q <= 1'b0;
                            st_q   <= S_WB;
                        end else if (buf_full) begin
                            more_q <= 1'b1;
                            st_q   <= S_WB;
                        end
                    end
                end
                S_WB: begin
                    cur_q <= link_q;
                    if (!more_q) in_frame_q <= 1'b0;
                    st_q  <= S_RD_STS;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R4
    wb_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (e_we && e_be == 4'hF) |-> e_wdata[31]);

    // R7
    spill_count_chk: assert property (@(posedge clk) disable iff (rst)
        (e_we && e_be == 4'hF && e_wdata[30]) |-> (e_wdata[SZ_W-1:0] == size_q && e_wdata[29:12] == '0));

    // R8
    link_follow_chk: assert property (@(posedge clk) disable iff (rst)
        desc_done |=> (cur_q == $past(link_q)));

    // R12
    fetch_stall_chk: assert property (@(posedge clk) disable iff (rst)
        desc_done |=> !in_ready);

    // R10
    stay_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (idle && !rx_start && !pend_q) |=> idle);

    // R9
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !e_we);

endmodule

// File: rtl/rxr_ring_engine.sv
`timescale 1ns/1ps
module rxr_ring_engine #(
    parameter int MEM_WORDS = 2048,
    parameter int MAX_LEN   = 1518,
    parameter int TOT_W     = 16,
    parameter int MISS_W    = 16,
    localparam int AW       = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_start,
    input  logic              ring_load,
    input  logic [AW-1:0]     ring_addr,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic [7:0]        in_err,
    input  logic [1:0]        in_dest,
    output logic              in_ready,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              desc_done,
    output logic              eng_idle,
    output logic [MISS_W-1:0] missed_count
);
    logic          e_we;
    logic [3:0]    e_be;
    logic [AW-1:0] e_addr;
    logic [31:0]   e_wdata;
    logic [31:0]   e_rdata;
    logic          miss_inc;

    rxr_ctrl #(
        .AW      (AW),
        .MAX_LEN (MAX_LEN),
        .TOT_W   (TOT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .rx_start  (rx_start),
        .ring_load (ring_load),
        .ring_addr (ring_addr),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .in_err    (in_err),
        .in_dest   (in_dest),
        .in_ready  (in_ready),
        .e_we      (e_we),
        .e_be      (e_be),
        .e_addr    (e_addr),
        .e_wdata   (e_wdata),
        .e_rdata   (e_rdata),
        .desc_done (desc_done),
        .idle      (eng_idle),
        .miss_inc  (miss_inc)
    );

    rxr_mem #(
        .WORDS (MEM_WORDS)
    ) u_mem (
        .clk     (clk),
        .h_we    (host_we),
        .h_addr  (host_addr),
        .h_wdata (host_wdata),
        .h_rdata (host_rdata),
        .e_we    (e_we),
        .e_be    (e_be),
        .e_addr  (e_addr),
        .e_wdata (e_wdata),
        .e_rdata (e_rdata)
    );

    rxr_miss_ctr #(
        .W (MISS_W)
    ) u_miss (
        .clk   (clk),
        .rst   (rst),
        .inc   (miss_inc),
        .count (missed_count)
    );

endmodule

// File: tb/rxr_ring_engine_tb.sv
`timescale 1ns/1ps
module rxr_ring_engine_tb;
    localparam int AW = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rx_start = 1'b0;
    logic          ring_load = 1'b0;
    logic [AW-1:0] ring_addr = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic [7:0]    in_err = '0;
    logic [1:0]    in_dest = '0;
    logic          in_ready;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic          desc_done;
    logic          eng_idle;
    logic [15:0]   missed_count;

    int checks = 0;
    int failures = 0;
    int done_pulses = 0;

    always #5 clk = ~clk;

    rxr_ring_engine u_dut (
        .clk          (clk),
        .rst          (rst),
        .rx_start     (rx_start),
        .ring_load    (ring_load),
        .ring_addr    (ring_addr),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_last      (in_last),
        .in_err       (in_err),
        .in_dest      (in_dest),
        .in_ready     (in_ready),
        .host_we      (host_we),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .desc_done    (desc_done),
        .eng_idle     (eng_idle),
        .missed_count (missed_count)
    );

    always @(negedge clk) if (!rst && desc_done) done_pulses++;

    function automatic int dsc(input int i); return 16 + 4 * i; endfunction
    function automatic int bufw(input int i); return 64 + 384 * i; endfunction
    function automatic logic [31:0] word_of(input logic [7:0] seed, input int k);
        return {seed + 8'(k + 3), seed + 8'(k + 2), seed + 8'(k + 1), seed + 8'(k)};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic host_wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        host_we = 1'b1; host_addr = AW'(addr); host_wdata = data;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        host_addr = AW'(addr);
        #1 data = host_rdata;
    endtask

    task automatic mem_check(input string req, input int addr, input logic [31:0] exp);
        logic [31:0] v;
        host_rd(addr, v);
        check(req, v, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed,
                              input logic [7:0] err, input logic [1:0] dest);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = seed + 8'(k); in_last = (k == len - 1);
            in_err = err; in_dest = dest;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_err = '0; in_dest = '0;
    endtask

    task automatic load_ptr(input int addr);
        @(negedge clk);
        ring_load = 1'b1; ring_addr = AW'(addr);
        @(negedge clk);
        ring_load = 1'b0;
    endtask

    task automatic start_engine(input string req);
        @(negedge clk);
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
        #1 check(req, {31'd0, in_ready}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1 idle", {31'd0, eng_idle}, 32'd1);
        check("R1 ready", {31'd0, in_ready}, 32'd1);
        check("R1 missed", {16'd0, missed_count}, 32'd0);
    endtask

    task automatic t_setup;
        for (int i = 0; i < 4; i++) begin
            host_wr(dsc(i) + 0, 32'(dsc((i + 1) % 4) * 4));
            host_wr(dsc(i) + 1, (i == 3) ? 32'd16 : 32'h600);
            host_wr(dsc(i) + 2, 32'(bufw(i) * 4));
        end
    endtask

    task automatic t_drop_before_start;
        send_frame(3, 8'h01, 8'h00, 2'd0);
        wait_cyc(4);
        check("R9 missed first drop", {16'd0, missed_count}, 32'd1);
        check("R10 stays idle without start", {31'd0, eng_idle}, 32'd1);
        mem_check("R9 no write-back while idle", dsc(0) + 1, 32'h600);
    endtask

    task automatic t_first_frame;
        load_ptr(dsc(0));
        start_engine("R12 ready low after start");
        send_frame(64, 8'h10, 8'h00, 2'd0);
        wait_cyc(6);
        mem_check("R4 good status d0", dsc(0) + 1, 32'h8800_0040);
        mem_check("R3 first word", bufw(0), word_of(8'h10, 0));
        mem_check("R3 last word", bufw(0) + 15, word_of(8'h10, 60));
        check("R2 active after start", {31'd0, eng_idle}, 32'd0);
    endtask

    task automatic t_error_frame;
        wait_cyc(4);
        load_ptr(dsc(3));
        send_frame(10, 8'h40, 8'h08, 2'd2);
        wait_cyc(6);
        mem_check("R11 R5 status lands in d1", dsc(1) + 1, 32'h8108_000A);
        mem_check("R8 data in next buffer", bufw(1), word_of(8'h40, 0));
    endtask

    task automatic t_long_frame;
        send_frame(1520, 8'h00, 8'h00, 2'd0);
        wait_cyc(6);
        mem_check("R6 long status d2", dsc(2) + 1, 32'h8040_05F0);
        mem_check("R3 long first word", bufw(2), word_of(8'h00, 0));
        mem_check("R3 long last word", bufw(2) + 379, 32'hEFEE_EDEC);
    endtask

    task automatic t_spill;
        host_wr(dsc(0) + 1, 32'h600);
        send_frame(20, 8'hA0, 8'h00, 2'd0);
        wait_cyc(6);
        mem_check("R7 continued status d3", dsc(3) + 1, 32'hC000_0010);
        mem_check("R7 first part", bufw(3) + 3, word_of(8'hA0, 12));
        mem_check("R8 wrap status d0", dsc(0) + 1, 32'h8800_0004);
        mem_check("R7 remainder in d0", bufw(0), word_of(8'hA0, 16));
    endtask

    task automatic t_owned_stop;
        check("R9 idle on owned d1", {31'd0, eng_idle}, 32'd1);
        send_frame(5, 8'h77, 8'h00, 2'd0);
        wait_cyc(4);
        check("R9 missed second drop", {16'd0, missed_count}, 32'd2);
        mem_check("R9 d1 buffer untouched", bufw(1), word_of(8'h40, 0));
        mem_check("R9 d1 status untouched", dsc(1) + 1, 32'h8108_000A);
    endtask

    task automatic t_restart;
        host_wr(dsc(1) + 1, 32'h600);
        start_engine("R12 ready low on restart");
        send_frame(8, 8'h55, 8'h00, 2'd0);
        wait_cyc(8);
        mem_check("R10 restart reuses d1", dsc(1) + 1, 32'h8800_0008);
        mem_check("R10 restart data", bufw(1), word_of(8'h55, 0));
        check("R9 idle on owned d2", {31'd0, eng_idle}, 32'd1);
        check("R12 done pulse count", 32'(done_pulses), 32'd6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_setup();
        t_drop_before_start();
        t_first_frame();
        t_error_frame();
        t_long_frame();
        t_spill();
        t_owned_stop();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule